// File: doc/BRIEF.md
# Sixteen-Bit Nibble Block Cipher

This block encrypts or decrypts one 16-bit word with a small two-round cipher built like AES. The word is treated as a 2x2 matrix of 4-bit nibbles. Each round uses a 16-entry nibble substitution, a swap within the second row, and a column mix over GF(16). Key expansion happens outside the block. The three 16-bit round keys enter on their own ports, and the same three keys serve both directions.

A request is offered with `in_valid`. It is accepted on a rising edge where `in_ready` is also high. The first round is computed combinationally from the inputs and stored at the accepting edge. The second round is stored at the next edge, and `out_valid` is then high for exactly one cycle. While a request is in flight, `in_ready` is low, so the block takes at most one word every two cycles. The result port has no back-pressure: `out_data` holds its value until the next completion, and a consumer must take it on the cycle `out_valid` is high, or at any time before the next result.

Top module: `nibble_cipher`

## Requirements
- R1: Encryption (`in_decrypt`=0) applies, in order: XOR with rk0; forward S-box on each nibble; second-row swap; mix by [1 4; 4 1]; XOR rk1; forward S-box; second-row swap; XOR rk2.
  - Nibble mapping is s00=[15:12], s10=[11:8], s01=[7:4], s11=[3:0], so the row swap exchanges [11:8] with [3:0].
  - The forward S-box for indices 0..F is 9,4,A,B,D,1,8,5,6,2,0,3,C,E,F,7.
  - GF(16) uses the reduction polynomial x^4+x+1.
- R2: Decryption (`in_decrypt`=1) applies, in order: XOR rk2; row swap; inverse S-box; XOR rk1; mix by [9 2; 2 9]; row swap; inverse S-box; XOR rk0.
  - The inverse S-box for indices 0..F is A,5,9,B,1,7,8,F,6,0,2,3,C,4,D,E.
- R3: Encrypting 0x6F6B with rk0=0xA73B, rk1=0x1C27 and rk2=0x7651 yields 0x0738.
- R4: Decrypting 0x0738 with the same three keys yields 0x6F6B.
- R5: Decrypting a ciphertext with the keys that produced it returns the original word.
- R6: After a request is accepted at edge N, `out_valid` is low after edge N, high after edge N+1, and low again after edge N+2.
- R7: `in_ready` is low for the one cycle after an acceptance. An `in_valid` raised during that cycle is ignored: it produces no extra `out_valid` and does not change `out_data`.
- R8: The data, keys and mode are sampled only at the accepting edge. Changing them while the request is in flight does not alter its result.
- R9: While `rst_n` is low and after it is released, `out_valid` is 0, `in_ready` is 1 and `out_data` is 0. A reset during a request cancels that request.
- R10: `out_data` holds its value on every cycle in which `out_valid` is not newly raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block idle; request accepted when both are high |
| in_decrypt | input | 1 | 0 = encrypt, 1 = decrypt |
| in_data | input | 16 | Plaintext or ciphertext word |
| rk0 | input | 16 | Round key 0 |
| rk1 | input | 16 | Round key 1 |
| rk2 | input | 16 | Round key 2 |
| out_valid | output | 1 | One-cycle completion pulse |
| out_data | output | 16 | Result, held until the next completion |

## Verification
The main function is tested with several kinds of input:

- **Published vector.** The known encrypt/decrypt pair pins down the nibble mapping and the table contents.
- **All-zero and all-one words and keys.** These expose a transposed S-box entry or a wrong reduction polynomial, which the published pair may not reach.
- **Single-bit words.** A word with one bit set in each row shows whether the row swap acts on the right nibbles.
- **Round trips.** Decrypting every ciphertext with its own keys separates a wrong inverse matrix from a wrong forward matrix.

Further directed tests cover the remaining rules:

- a request offered while busy;
- inputs changed while a request is in flight;
- a reset that lands mid-request.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  localparam int NIB_W = 4;
  localparam int NIB_N = 4;
  localparam int BLK_W = NIB_W * NIB_N;
  localparam int COL_W = 2 * NIB_W;
  localparam int COL_N = NIB_N / 2;
  // low terms of x^4 + x + 1
  localparam logic [NIB_W-1:0] RED_POLY = 4'h3;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [BLK_W-1:0] blk_t;

  function automatic nib_t gf_mul(nib_t a, nib_t b);
    nib_t acc;
    nib_t m;
    acc = '0;
    m = a;
    for (int i = 0; i < NIB_W; i++) begin
      if (b[i]) acc = acc ^ m;
      if (m[NIB_W-1]) m = (m << 1) ^ RED_POLY;
      else m = m << 1;
    end
    return acc;
  endfunction

  // second row (s10, s11) exchanged; first row untouched
  function automatic blk_t row_swap(blk_t s);
    return {s[BLK_W-1 -: NIB_W], s[NIB_W-1:0],
            s[2*NIB_W-1 -: NIB_W], s[3*NIB_W-1 -: NIB_W]};
  endfunction

  function automatic nib_t sbox_fwd(nib_t n);
    case (n)
      4'h0: return 4'h9;  4'h1: return 4'h4;  4'h2: return 4'hA;  4'h3: return 4'hB;
      4'h4: return 4'hD;  4'h5: return 4'h1;  4'h6: return 4'h8;  4'h7: return 4'h5;
      4'h8: return 4'h6;  4'h9: return 4'h2;  4'hA: return 4'h0;  4'hB: return 4'h3;
      4'hC: return 4'hC;  4'hD: return 4'hE;  4'hE: return 4'hF;  default: return 4'h7;
    endcase
  endfunction

  function automatic nib_t sbox_inv(nib_t n);
    case (n)
      4'h0: return 4'hA;  4'h1: return 4'h5;  4'h2: return 4'h9;  4'h3: return 4'hB;
      4'h4: return 4'h1;  4'h5: return 4'h7;  4'h6: return 4'h8;  4'h7: return 4'hF;
      4'h8: return 4'h6;  4'h9: return 4'h0;  4'hA: return 4'h2;  4'hB: return 4'h3;
      4'hC: return 4'hC;  4'hD: return 4'h4;  4'hE: return 4'hD;  default: return 4'hE;
    endcase
  endfunction
endpackage

// File: rtl/nbc_sub.sv
module nbc_sub
  import nbc_pkg::*;
#(
  parameter bit INV = 1'b0
) (
  input  logic [BLK_W-1:0] din,
  output logic [BLK_W-1:0] dout
);
  for (genvar g = 0; g < NIB_N; g++) begin : g_lane
    if (INV) begin : g_inv
      assign dout[g*NIB_W +: NIB_W] = sbox_inv(din[g*NIB_W +: NIB_W]);
    end else begin : g_fwd
      assign dout[g*NIB_W +: NIB_W] = sbox_fwd(din[g*NIB_W +: NIB_W]);
    end
  end
endmodule

// File: rtl/nbc_mix.sv
module nbc_mix
  import nbc_pkg::*;
#(
  parameter bit INV = 1'b0
) (
  input  logic [BLK_W-1:0] din,
  output logic [BLK_W-1:0] dout
);
  localparam nib_t C_DIAG = INV ? 4'h9 : 4'h1;
  localparam nib_t C_OFF  = INV ? 4'h2 : 4'h4;

  for (genvar c = 0; c < COL_N; c++) begin : g_col
    nib_t top_n, bot_n;
    assign top_n = din[BLK_W-1-c*COL_W -: NIB_W];
    assign bot_n = din[BLK_W-1-c*COL_W-NIB_W -: NIB_W];
    assign dout[BLK_W-1-c*COL_W -: NIB_W] =
      gf_mul(C_DIAG, top_n) ^ gf_mul(C_OFF, bot_n);
    assign dout[BLK_W-1-c*COL_W-NIB_W -: NIB_W] =
      gf_mul(C_OFF, top_n) ^ gf_mul(C_DIAG, bot_n);
  end
endmodule

// File: rtl/nibble_cipher.sv
module nibble_cipher
  import nbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_decrypt,
  input  logic [BLK_W-1:0] in_data,
  input  logic [BLK_W-1:0] rk0,
  input  logic [BLK_W-1:0] rk1,
  input  logic [BLK_W-1:0] rk2,
  output logic             out_valid,
  output logic [BLK_W-1:0] out_data
);
  // ---- round one, from the ports ----
  blk_t e1_sb, e1_mx, e1_res;
  blk_t d1_sb, d1_res;
  blk_t s1_state, s1_key;
  logic s1_vld, s1_dec;

  nbc_sub #(.INV(1'b0)) u_e1_sub (.din(in_data ^ rk0), .dout(e1_sb));
  nbc_mix #(.INV(1'b0)) u_e1_mix (.din(row_swap(e1_sb)), .dout(e1_mx));
  assign e1_res = e1_mx ^ rk1;

  nbc_sub #(.INV(1'b1)) u_d1_sub (.din(row_swap(in_data ^ rk2)), .dout(d1_sb));
  nbc_mix #(.INV(1'b1)) u_d1_mix (.din(d1_sb ^ rk1), .dout(d1_res));

  assign in_ready = !s1_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_dec   <= 1'b0;
      s1_state <= '0;
      s1_key   <= '0;
    end else if (in_valid && in_ready) begin
      s1_vld   <= 1'b1;
      s1_dec   <= in_decrypt;
      s1_state <= in_decrypt ? d1_res : e1_res;
      s1_key   <= in_decrypt ? rk0 : rk2;
    end else begin
      s1_vld   <= 1'b0;
    end
  end

  // ---- round two, from the stage register ----
  blk_t e2_sb, d2_sb, r2_res;
  nbc_sub #(.INV(1'b0)) u_e2_sub (.din(s1_state), .dout(e2_sb));
  nbc_sub #(.INV(1'b1)) u_d2_sub (.din(row_swap(s1_state)), .dout(d2_sb));
  assign r2_res = s1_dec ? (d2_sb ^ s1_key) : (row_swap(e2_sb) ^ s1_key);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_vld;
      if (s1_vld) out_data <= r2_res;
    end
  end

  // ---- checks ----
  p_accept_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!out_valid ##1 out_valid));
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_busy_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);
  p_done_needs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(!in_ready));
  p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
endmodule

// File: tb/tb_nibble_cipher.sv
module tb_nibble_cipher;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_decrypt = 1'b0;
  logic [W-1:0] in_data = '0, rk0 = '0, rk1 = '0, rk2 = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_data;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_cipher dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_decrypt(in_decrypt), .in_data(in_data), .rk0(rk0), .rk1(rk1), .rk2(rk2),
    .out_valid(out_valid), .out_data(out_data));

  // stimulus: {decrypt, data, rk0, rk1, rk2}
  localparam logic [64:0] VECS [0:7] = '{
    {1'b0, 16'h6F6B, 16'hA73B, 16'h1C27, 16'h7651},
    {1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    {1'b0, 16'h0100, 16'h0000, 16'h0000, 16'h0000},
    {1'b0, 16'h0001, 16'h1234, 16'h5678, 16'h9ABC},
    {1'b1, 16'h0738, 16'hA73B, 16'h1C27, 16'h7651},
    {1'b1, 16'hBEEF, 16'hC0DE, 16'h4321, 16'h0F0F},
    {1'b0, 16'h8421, 16'h3C3C, 16'hA5A5, 16'h5A5A}
  };

  localparam logic [3:0] FWD [0:15] = '{4'h9,4'h4,4'hA,4'hB,4'hD,4'h1,4'h8,4'h5,
                                        4'h6,4'h2,4'h0,4'h3,4'hC,4'hE,4'hF,4'h7};
  localparam logic [3:0] INV [0:15] = '{4'hA,4'h5,4'h9,4'hB,4'h1,4'h7,4'h8,4'hF,
                                        4'h6,4'h0,4'h2,4'h3,4'hC,4'h4,4'hD,4'hE};

  function automatic logic [3:0] m_mul(logic [3:0] a, logic [3:0] b);
    logic [7:0] p = '0;
    for (int i = 0; i < 4; i++) if (b[i]) p = p ^ (8'(a) << i);
    for (int i = 7; i >= 4; i--) if (p[i]) p = p ^ (8'h13 << (i - 4));
    return p[3:0];
  endfunction

  function automatic logic [15:0] m_sub(logic [15:0] x, bit inv);
    logic [15:0] r;
    for (int i = 0; i < 4; i++) r[i*4 +: 4] = inv ? INV[x[i*4 +: 4]] : FWD[x[i*4 +: 4]];
    return r;
  endfunction

  function automatic logic [15:0] m_swp(logic [15:0] x);
    return {x[15:12], x[3:0], x[7:4], x[11:8]};
  endfunction

  function automatic logic [15:0] m_mix(logic [15:0] x, logic [3:0] d, logic [3:0] o);
    return {m_mul(d, x[15:12]) ^ m_mul(o, x[11:8]), m_mul(o, x[15:12]) ^ m_mul(d, x[11:8]),
            m_mul(d, x[7:4]) ^ m_mul(o, x[3:0]),   m_mul(o, x[7:4]) ^ m_mul(d, x[3:0])};
  endfunction

  function automatic logic [15:0] model(bit dec, logic [15:0] x,
                                        logic [15:0] k0, logic [15:0] k1, logic [15:0] k2);
    if (!dec) begin
      x = m_mix(m_swp(m_sub(x ^ k0, 1'b0)), 4'h1, 4'h4) ^ k1;
      return m_swp(m_sub(x, 1'b0)) ^ k2;
    end
    x = m_mix(m_sub(m_swp(x ^ k2), 1'b1) ^ k1, 4'h9, 4'h2);
    return m_sub(m_swp(x), 1'b1) ^ k0;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // full request; inputs raised at a falling edge, results sampled at falling edges
  task automatic run(bit dec, logic [15:0] d, logic [15:0] k0, logic [15:0] k1,
                     logic [15:0] k2, output logic [15:0] res);
    @(negedge clk);
    in_decrypt = dec; in_data = d; rk0 = k0; rk1 = k1; rk2 = k2; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 busy ready", {15'd0, in_ready}, 16'd0);
    check("R6 no early valid", {15'd0, out_valid}, 16'd0);
    @(negedge clk);
    check("R6 valid on time", {15'd0, out_valid}, 16'd1);
    res = out_data;
    @(negedge clk);
    check("R6 pulse ends", {15'd0, out_valid}, 16'd0);
    check("R10 result held", out_data, res);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] r, r2, first;
    // R9 reset state
    #(CLK_PERIOD*2);
    check("R9 reset valid", {15'd0, out_valid}, 16'd0);
    check("R9 reset ready", {15'd0, in_ready}, 16'd1);
    check("R9 reset data", out_data, 16'd0);
    @(negedge clk); rst_n = 1'b1;

    // vector table
    for (int i = 0; i < 8; i++) begin
      logic [64:0] v = VECS[i];
      run(v[64], v[63:48], v[47:32], v[31:16], v[15:0], r);
      check(v[64] ? "R2 decrypt" : "R1 encrypt", r,
            model(v[64], v[63:48], v[47:32], v[31:16], v[15:0]));
      run(!v[64], r, v[47:32], v[31:16], v[15:0], r2);
      check("R5 round trip", r2, v[63:48]);
    end

    // R3 and R4 published pair
    run(1'b0, 16'h6F6B, 16'hA73B, 16'h1C27, 16'h7651, r);
    check("R3 known ciphertext", r, 16'h0738);
    run(1'b1, 16'h0738, 16'hA73B, 16'h1C27, 16'h7651, r);
    check("R4 known plaintext", r, 16'h6F6B);

    // R7 request while busy ignored; R8 inputs changed in flight
    @(negedge clk);
    in_decrypt = 1'b0; in_data = 16'h6F6B; rk0 = 16'hA73B; rk1 = 16'h1C27; rk2 = 16'h7651;
    in_valid = 1'b1;
    @(negedge clk);
    in_decrypt = 1'b1; in_data = 16'h1234; rk0 = 16'h1111; rk1 = 16'h2222; rk2 = 16'h3333;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 inflight inputs", out_data, 16'h0738);
    check("R7 valid first only", {15'd0, out_valid}, 16'd1);
    first = out_data;
    @(negedge clk);
    check("R7 no extra valid", {15'd0, out_valid}, 16'd0);
    @(negedge clk);
    check("R7 no extra valid later", {15'd0, out_valid}, 16'd0);
    check("R7 result unchanged", out_data, first);

    // R9 reset mid-request cancels it
    @(negedge clk);
    in_decrypt = 1'b0; in_data = 16'h0000; rk0 = '0; rk1 = '0; rk2 = '0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b0;
    #1;
    check("R9 reset clears data", out_data, 16'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R9 cancelled no valid", {15'd0, out_valid}, 16'd0);
    check("R9 ready after reset", {15'd0, in_ready}, 16'd1);
    @(negedge clk);
    check("R9 still no valid", {15'd0, out_valid}, 16'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule